// File: doc/BRIEF.md
# Sector-Line Subblock Coherence Controller

This block holds the coherence state of one line of a snooping sector cache. The line has a single address tag and is split into a parameter-set number of subblocks. Each subblock carries its own two-bit state, and one exclusivity flag applies to the whole line. The line-level state is never stored. It is derived each cycle from the subblock states and the flag. Every transaction on the shared bus carries a bitmask with one bit per subblock, so a remote write removes only the subblocks it names and leaves the rest of the line resident.

On the processor side, a request names a tag, a subblock index and a direction. The block answers in the same cycle with the hit indication, the bus transaction to issue with its mask, and the mask of dirty subblocks to write back when the line is reallocated. It assumes the transaction completes in that cycle: fill data arrive under `fill_mask`, and `fill_shared` reports whether another cache holds the line. On the snoop side, a remote read miss, write miss or invalidate is checked against the tag. The block returns the mask of subblocks it supplies and updates its states at the next clock edge. Data storage, memory and bus arbitration sit outside.

Top module: `sector_line_coh`

## Requirements
- R1: After reset, every subblock is Invalid (code 0), the line state is Invalid (code 0), and `bus_op` is none (code 0).
- R2: `blk_state` is Invalid (0) only when no subblock is valid. It is Valid Exclusive (1) when the exclusivity flag is set. Otherwise it is Dirty Shared (3) when any subblock is Dirty Shared or Dirty, and Clean Shared (2) in the remaining cases. Subblock codes are Invalid 0, Clean 1, Dirty Shared 2 and Dirty 3, with subblock i at `sub_state[2i+1:2i]`.
- R3: A read whose tag differs from the line tag, or whose subblock is Invalid, issues read-miss (code 1) with a one-hot mask at the index. Every Invalid subblock in `fill_mask` plus the requested one becomes Clean. On a tag mismatch the line is reallocated, and it is exclusive exactly when `fill_shared` is low.
- R4: A write that hits a Clean or Dirty Shared subblock issues invalidate (code 3) with a one-hot mask, unless the line is Valid Exclusive, in which case no bus transaction is issued. In either case the subblock becomes Dirty. A write miss issues write-miss (code 2) and leaves the subblock Dirty.
- R5: A read of any valid subblock under a matching tag, and a write to a Dirty subblock, report `cpu_hit` and issue no bus transaction.
- R6: When a request with a different tag reallocates a valid line, `wb_mask` lists exactly the Dirty and Dirty Shared subblocks of the old line. A line with only Clean subblocks is replaced with `wb_mask` zero.
- R7: A matching snooped write-miss (2) or invalidate (3) makes Invalid only the subblocks in `snp_mask`. A write-miss also sets in `sup_mask` those masked subblocks that are Dirty or Dirty Shared.
- R8: A matching snooped read-miss (1) sets in `sup_mask` the requested valid subblocks together with every Clean and Dirty Shared subblock. Requested Dirty subblocks move to Dirty Shared, and the line loses exclusivity.
- R9: A snoop whose tag does not match, or that arrives while the line is Invalid, gives `snp_hit` low and `sup_mask` zero, and changes no state.
- R10: When `snp_valid` and `cpu_req` are both high, the snoop is applied. `cpu_ack`, `cpu_hit` and `bus_op` stay zero, and the processor request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_tag | input | TAG_W | Request tag |
| cpu_idx | input | $clog2(NSUB) | Requested subblock |
| fill_mask | input | NSUB | Subblocks delivered by the bus on a read miss |
| fill_shared | input | 1 | Another cache holds the line |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_op | input | 2 | Snooped transaction code |
| snp_tag | input | TAG_W | Snooped tag |
| snp_mask | input | NSUB | Snooped subblock mask |
| cpu_ack | output | 1 | Processor request accepted this cycle |
| cpu_hit | output | 1 | Requested subblock present |
| bus_op | output | 2 | Transaction to issue |
| bus_mask | output | NSUB | Mask of the issued transaction |
| wb_mask | output | NSUB | Subblocks needing write-back on reallocation |
| snp_hit | output | 1 | Snoop matched a valid line |
| sup_mask | output | NSUB | Subblocks supplied to the snooped requester |
| blk_state | output | 2 | Derived line state |
| sub_state | output | 2*NSUB | Current subblock states |

## Verification
The vectors go after the write to a Clean subblock. A design that ignored the exclusivity flag would broadcast an invalidate from a Valid Exclusive line, and one that trusted a stale flag would stay silent on a shared line. The snoop cases check that a remote invalidate or write-miss clears only the named bit; a design that cleared the whole line would show other subblocks dropping to zero. They also check that a remote read supplies every shared subblock while demoting only the requested Dirty one. The vectors also cover eviction of a line holding only Clean subblocks, where a spurious write-back mask would appear, a snoop with a foreign tag that must leave the line untouched, and a processor request in the same cycle as a snoop that must be dropped entirely.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      S_INV = 2'd0,
      S_CLN = 2'd1,
      S_DSH = 2'd2,
      S_DRT = 2'd3
   } sub_st_t;

   typedef enum logic [1:0] {
      B_INV = 2'd0,
      B_VEX = 2'd1,
      B_CSH = 2'd2,
      B_DSH = 2'd3
   } blk_st_t;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RDM  = 2'd1,
      OP_WRM  = 2'd2,
      OP_INV  = 2'd3
   } bus_op_t;
endpackage

// File: rtl/sbc_blk_state.sv
module sbc_blk_state
   import sbc_pkg::*;
#(
   parameter int NSUB = 8
) (
   input  sub_st_t [NSUB-1:0] st,
   input  logic               excl,
   output blk_st_t            blk,
   output logic [NSUB-1:0]    valid_m,
   output logic [NSUB-1:0]    dirty_m,
   output logic [NSUB-1:0]    share_m
);
   for (genvar i = 0; i < NSUB; i++) begin : g_cls
      assign valid_m[i] = (st[i] != S_INV);
      assign dirty_m[i] = (st[i] == S_DSH) || (st[i] == S_DRT);
      assign share_m[i] = (st[i] == S_CLN) || (st[i] == S_DSH);
   end

   always_comb begin
      if (valid_m == '0)      blk = B_INV;
      else if (excl)          blk = B_VEX;
      else if (dirty_m != '0) blk = B_DSH;
      else                    blk = B_CSH;
   end
endmodule

// File: rtl/sbc_cpu_path.sv
module sbc_cpu_path
   import sbc_pkg::*;
#(
   parameter int NSUB  = 8,
   localparam int IDX_W = $clog2(NSUB)
) (
   input  logic               req,
   input  logic               wr,
   input  logic [IDX_W-1:0]   idx,
   input  logic               tag_hit,
   input  logic [NSUB-1:0]    fill_m,
   input  logic               shr,
   input  sub_st_t [NSUB-1:0] st,
   input  logic               excl,
   input  logic [NSUB-1:0]    dirty_m,
   output logic               hit,
   output bus_op_t            bop,
   output logic [NSUB-1:0]    bmask,
   output logic [NSUB-1:0]    wb,
   output sub_st_t [NSUB-1:0] nxt,
   output logic               nxt_excl
);
   logic [NSUB-1:0] onehot;
   logic [NSUB-1:0] want;
   logic            sub_ok;
   sub_st_t         cur;

   assign onehot = NSUB'(1) << idx;
   assign want   = fill_m | onehot;
   assign cur    = st[idx];
   assign sub_ok = tag_hit && (cur != S_INV);
   assign hit    = req && sub_ok;

   always_comb begin
      bop      = OP_NONE;
      bmask    = '0;
      wb       = '0;
      nxt      = st;
      nxt_excl = excl;
      if (req) begin
         if (!tag_hit) begin
            wb       = dirty_m;
            nxt_excl = !shr;
            for (int i = 0; i < NSUB; i++) nxt[i] = S_INV;
         end else if (!sub_ok) begin
            nxt_excl = excl && !shr;
         end
         if (!wr) begin
            if (!sub_ok) begin
               bop   = OP_RDM;
               bmask = onehot;
               for (int i = 0; i < NSUB; i++)
                  if (want[i] && nxt[i] == S_INV) nxt[i] = S_CLN;
            end
         end else begin
            if (!sub_ok) begin
               bop   = OP_WRM;
               bmask = onehot;
            end else if (cur != S_DRT && !excl) begin
               bop   = OP_INV;
               bmask = onehot;
            end
            nxt[idx] = S_DRT;
         end
      end
   end
endmodule

// File: rtl/sbc_snoop_path.sv
module sbc_snoop_path
   import sbc_pkg::*;
#(
   parameter int NSUB = 8
) (
   input  logic               match,
   input  bus_op_t            op,
   input  logic [NSUB-1:0]    mask,
   input  sub_st_t [NSUB-1:0] st,
   input  logic               excl,
   input  logic [NSUB-1:0]    valid_m,
   input  logic [NSUB-1:0]    dirty_m,
   input  logic [NSUB-1:0]    share_m,
   output logic [NSUB-1:0]    sup,
   output sub_st_t [NSUB-1:0] nxt,
   output logic               nxt_excl
);
   always_comb begin
      sup      = '0;
      nxt      = st;
      nxt_excl = excl;
      if (match) begin
         unique case (op)
            OP_RDM: begin
               sup      = (mask & valid_m) | share_m;
               nxt_excl = 1'b0;
               for (int i = 0; i < NSUB; i++)
                  if (mask[i] && st[i] == S_DRT) nxt[i] = S_DSH;
            end
            OP_WRM, OP_INV: begin
               if (op == OP_WRM) sup = mask & dirty_m;
               for (int i = 0; i < NSUB; i++)
                  if (mask[i]) nxt[i] = S_INV;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sector_line_coh.sv
module sector_line_coh
   import sbc_pkg::*;
#(
   parameter int NSUB  = 8,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(NSUB),
   localparam int ST_W  = 2 * NSUB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_wr,
   input  logic [TAG_W-1:0] cpu_tag,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic [NSUB-1:0]  fill_mask,
   input  logic             fill_shared,
   input  logic             snp_valid,
   input  logic [1:0]       snp_op,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [NSUB-1:0]  snp_mask,
   output logic             cpu_ack,
   output logic             cpu_hit,
   output logic [1:0]       bus_op,
   output logic [NSUB-1:0]  bus_mask,
   output logic [NSUB-1:0]  wb_mask,
   output logic             snp_hit,
   output logic [NSUB-1:0]  sup_mask,
   output logic [1:0]       blk_state,
   output logic [ST_W-1:0]  sub_state
);
   if (NSUB < 2) begin : g_bad_nsub
      $error("sector_line_coh: NSUB must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("sector_line_coh: TAG_W must be at least 1");
   end

   sub_st_t [NSUB-1:0] st_q, st_d, cpu_nxt, snp_nxt;
   logic               excl_q, excl_d, cpu_excl, snp_excl;
   logic [TAG_W-1:0]   tag_q, tag_d;
   logic [NSUB-1:0]    valid_m, dirty_m, share_m;
   blk_st_t            blk;
   bus_op_t            cpu_bop;
   logic               line_valid, tag_hit, snp_match;

   sbc_blk_state #(.NSUB(NSUB)) u_blk (
      .st(st_q), .excl(excl_q), .blk(blk),
      .valid_m(valid_m), .dirty_m(dirty_m), .share_m(share_m)
   );

   assign line_valid = (valid_m != '0);
   assign tag_hit    = line_valid && (cpu_tag == tag_q);
   assign snp_match  = snp_valid && line_valid && (snp_tag == tag_q);
   assign cpu_ack    = cpu_req && !snp_valid;

   sbc_cpu_path #(.NSUB(NSUB)) u_cpu (
      .req(cpu_ack), .wr(cpu_wr), .idx(cpu_idx), .tag_hit(tag_hit),
      .fill_m(fill_mask), .shr(fill_shared), .st(st_q), .excl(excl_q),
      .dirty_m(dirty_m), .hit(cpu_hit), .bop(cpu_bop), .bmask(bus_mask),
      .wb(wb_mask), .nxt(cpu_nxt), .nxt_excl(cpu_excl)
   );

   sbc_snoop_path #(.NSUB(NSUB)) u_snp (
      .match(snp_match), .op(bus_op_t'(snp_op)), .mask(snp_mask),
      .st(st_q), .excl(excl_q), .valid_m(valid_m), .dirty_m(dirty_m),
      .share_m(share_m), .sup(sup_mask), .nxt(snp_nxt), .nxt_excl(snp_excl)
   );

   always_comb begin
      st_d   = st_q;
      excl_d = excl_q;
      tag_d  = tag_q;
      if (snp_valid) begin
         st_d   = snp_nxt;
         excl_d = snp_excl;
      end else if (cpu_ack) begin
         st_d   = cpu_nxt;
         excl_d = cpu_excl;
         tag_d  = cpu_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSUB; i++) st_q[i] <= S_INV;
         excl_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         st_q   <= st_d;
         excl_q <= excl_d;
         tag_q  <= tag_d;
      end
   end

   assign bus_op    = cpu_bop;
   assign snp_hit   = snp_match;
   assign blk_state = blk;
   assign sub_state = st_q;

   // R5: read hits and Dirty write hits stay off the bus
   p_quiet_read_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack && !cpu_wr && cpu_hit |-> bus_op == OP_NONE);
   p_quiet_dirty_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack && cpu_wr && tag_hit && st_q[cpu_idx] == S_DRT |-> bus_op == OP_NONE);

   // R4: every accepted write leaves its subblock Dirty
   p_write_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack && cpu_wr |=> st_q[$past(cpu_idx)] == S_DRT);

   // R8: remote read collects every shared subblock
   p_supply_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hit && snp_op == 2'd1 |-> (sup_mask & share_m) == share_m);

   // R10: a snoop blocks the processor side
   p_snoop_blocks_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ack && bus_op == OP_NONE && !cpu_hit);

   // R7: removal touches only the named subblocks
   for (genvar i = 0; i < NSUB; i++) begin : g_chk
      p_named_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         snp_valid && snp_op != 2'd1 && !snp_mask[i] |=> st_q[i] == $past(st_q[i]));
   end
endmodule

// File: tb/tb_sector_line_coh.sv
`timescale 1ns/100ps
module tb_sector_line_coh;
   localparam int NSUB  = 8;
   localparam int TAG_W = 20;
   localparam logic [19:0] TA = 20'h0A5A5;
   localparam logic [19:0] TB = 20'h1B6B6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_req = 1'b0, cpu_wr = 1'b0, fill_shared = 1'b0, snp_valid = 1'b0;
   logic [TAG_W-1:0] cpu_tag = '0, snp_tag = '0;
   logic [2:0]       cpu_idx = '0;
   logic [NSUB-1:0]  fill_mask = '0, snp_mask = '0;
   logic [1:0]       snp_op = '0;
   logic             cpu_ack, cpu_hit, snp_hit;
   logic [1:0]       bus_op, blk_state;
   logic [NSUB-1:0]  bus_mask, wb_mask, sup_mask;
   logic [15:0]      sub_state;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sector_line_coh #(.NSUB(NSUB), .TAG_W(TAG_W)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_tag(cpu_tag), .cpu_idx(cpu_idx), .fill_mask(fill_mask),
      .fill_shared(fill_shared), .snp_valid(snp_valid), .snp_op(snp_op),
      .snp_tag(snp_tag), .snp_mask(snp_mask), .cpu_ack(cpu_ack),
      .cpu_hit(cpu_hit), .bus_op(bus_op), .bus_mask(bus_mask),
      .wb_mask(wb_mask), .snp_hit(snp_hit), .sup_mask(sup_mask),
      .blk_state(blk_state), .sub_state(sub_state)
   );

   typedef struct packed {
      logic        cen, sen, wr;
      logic [19:0] tag;
      logic [2:0]  idx;
      logic [7:0]  fill;
      logic        shr;
      logic [1:0]  sop;
      logic [7:0]  smask;
      logic        e_ack, e_hit;
      logic [1:0]  e_bop;
      logic [7:0]  e_bmask, e_wb;
      logic        e_shit;
      logic [7:0]  e_sup;
      logic [1:0]  e_blk;
      logic [15:0] e_sub;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      // R3: cold read miss, exclusive fill
      '{1,0,0,TA,3'd2,8'h0F,0,2'd0,8'h00, 1,0,2'd1,8'h04,8'h00,0,8'h00,2'd1,16'h0055,4'd3},
      // R4: write Clean in Valid Exclusive, silent
      '{1,0,1,TA,3'd1,8'h00,0,2'd0,8'h00, 1,1,2'd0,8'h00,8'h00,0,8'h00,2'd1,16'h005D,4'd4},
      // R8: remote read of Dirty subblock 1
      '{0,1,0,TA,3'd0,8'h00,0,2'd1,8'h02, 0,0,2'd0,8'h00,8'h00,1,8'h0F,2'd3,16'h0059,4'd8},
      // R4: write Clean on shared line, invalidate
      '{1,0,1,TA,3'd0,8'h00,0,2'd0,8'h00, 1,1,2'd3,8'h01,8'h00,0,8'h00,2'd3,16'h005B,4'd4},
      // R7: remote invalidate of subblock 2 only
      '{0,1,0,TA,3'd0,8'h00,0,2'd3,8'h04, 0,0,2'd0,8'h00,8'h00,1,8'h00,2'd3,16'h004B,4'd7},
      // R7: remote write miss on Dirty subblock 0
      '{0,1,0,TA,3'd0,8'h00,0,2'd2,8'h01, 0,0,2'd0,8'h00,8'h00,1,8'h01,2'd3,16'h0048,4'd7},
      // R3: same tag, Invalid subblock, shared fill
      '{1,0,0,TA,3'd5,8'h30,1,2'd0,8'h00, 1,0,2'd1,8'h20,8'h00,0,8'h00,2'd3,16'h0548,4'd3},
      // R5: read of Dirty Shared subblock
      '{1,0,0,TA,3'd1,8'h00,0,2'd0,8'h00, 1,1,2'd0,8'h00,8'h00,0,8'h00,2'd3,16'h0548,4'd5},
      // R6: write to other tag evicts dirty subblock 1
      '{1,0,1,TB,3'd6,8'h00,0,2'd0,8'h00, 1,0,2'd2,8'h40,8'h02,0,8'h00,2'd1,16'h3000,4'd6},
      // R5: write to Dirty subblock
      '{1,0,1,TB,3'd6,8'h00,0,2'd0,8'h00, 1,1,2'd0,8'h00,8'h00,0,8'h00,2'd1,16'h3000,4'd5},
      // R9: snoop with foreign tag
      '{0,1,0,TA,3'd0,8'h00,0,2'd1,8'hFF, 0,0,2'd0,8'h00,8'h00,0,8'h00,2'd1,16'h3000,4'd9},
      // R2: last subblock removed, line Invalid
      '{0,1,0,TB,3'd0,8'h00,0,2'd3,8'h40, 0,0,2'd0,8'h00,8'h00,1,8'h00,2'd0,16'h0000,4'd2},
      // R2: shared fill gives Clean Shared line
      '{1,0,0,TB,3'd0,8'h03,1,2'd0,8'h00, 1,0,2'd1,8'h01,8'h00,0,8'h00,2'd2,16'h0005,4'd2},
      // R6: clean line replaced with no write-back
      '{1,0,0,TA,3'd0,8'h01,0,2'd0,8'h00, 1,0,2'd1,8'h01,8'h00,0,8'h00,2'd1,16'h0001,4'd6},
      // R10: processor write collides with snoop
      '{1,1,1,TA,3'd0,8'h00,0,2'd3,8'h01, 0,0,2'd0,8'h00,8'h00,1,8'h00,2'd0,16'h0000,4'd10}
   };

   task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic idle();
      cpu_req = 1'b0; snp_valid = 1'b0; cpu_wr = 1'b0;
      fill_mask = '0; fill_shared = 1'b0; snp_mask = '0; snp_op = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("reset blk", 1, 32'(blk_state), 32'h0);
      chk("reset sub", 1, 32'(sub_state), 32'h0);
      chk("reset bus_op", 1, 32'(bus_op), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cpu_req = VECS[v].cen; snp_valid = VECS[v].sen; cpu_wr = VECS[v].wr;
         cpu_tag = VECS[v].tag; snp_tag = VECS[v].tag; cpu_idx = VECS[v].idx;
         fill_mask = VECS[v].fill; fill_shared = VECS[v].shr;
         snp_op = VECS[v].sop; snp_mask = VECS[v].smask;
         #1;
         chk("cpu_ack", VECS[v].rq, 32'(cpu_ack), 32'(VECS[v].e_ack));
         chk("cpu_hit", VECS[v].rq, 32'(cpu_hit), 32'(VECS[v].e_hit));
         chk("bus_op", VECS[v].rq, 32'(bus_op), 32'(VECS[v].e_bop));
         chk("bus_mask", VECS[v].rq, 32'(bus_mask), 32'(VECS[v].e_bmask));
         chk("wb_mask", VECS[v].rq, 32'(wb_mask), 32'(VECS[v].e_wb));
         chk("snp_hit", VECS[v].rq, 32'(snp_hit), 32'(VECS[v].e_shit));
         chk("sup_mask", VECS[v].rq, 32'(sup_mask), 32'(VECS[v].e_sup));
         @(posedge clk);
         #1;
         idle();
         chk("blk_state", VECS[v].rq, 32'(blk_state), 32'(VECS[v].e_blk));
         chk("sub_state", VECS[v].rq, 32'(sub_state), 32'(VECS[v].e_sub));
      end

      // R1: reset in mid-run clears a populated line
      @(negedge clk);
      cpu_req = 1'b1; cpu_tag = TA; cpu_idx = 3'd3; fill_mask = 8'hFF;
      @(posedge clk);
      #1;
      idle();
      chk("filled sub", 3, 32'(sub_state), 32'h5555);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("mid-run reset blk", 1, 32'(blk_state), 32'h0);
      chk("mid-run reset sub", 1, 32'(sub_state), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule